// File: doc/BRIEF.md
# Byte-Lane Data Memory

This block is a synchronous data store organised as 64-bit words that serves loads and stores of 1, 2, 4 or 8 bytes at any byte address. The low three address bits select a byte inside the word, and the bits above them select the word. Inside a word the ordering is big-endian: the byte at offset 0 occupies the top eight bits, and the byte at offset 7 occupies the bottom eight bits. A narrow access therefore works on a fixed lane whose least significant bit sits at position (8 − size − offset) × 8.

A store that is narrower than a word merges into the existing word and leaves every other byte unchanged. An 8-byte store replaces the whole word. A load returns its lane shifted down to bit 0, with zeros above it. Read data comes out of a register one cycle after the request. Requests whose offset is not a multiple of the size, and requests whose size code is not 1, 2, 4 or 8, are rejected. A rejected request leaves storage untouched and produces a one-cycle error pulse.

Top module: `lane_mem`

## Requirements
- R1: While reset is held and in the first cycle after it, rdValid, errFlag and rdData are all 0.
- R2: The word index is byteAddr[3 +: log2(DEPTH)]. Address bits above that range are ignored, so two addresses that differ only there refer to the same word.
- R3: Byte offset k of a word (k = byteAddr[2:0]) occupies word bits [63−8k : 56−8k]. A load of size s at offset k returns the s×8 bits whose least significant bit is at (8−s−k)×8. The lowest-addressed byte is placed most significant, and the bits above s×8 are 0.
- R4: A store of size 1, 2 or 4 changes only the addressed bytes of the word. wrData bits at and above s×8 are ignored.
- R5: A store of size 8 at offset 0 replaces all 64 bits of the word with wrData.
- R6: A request whose offset is not a multiple of its size raises errFlag in the next cycle, leaves storage unchanged and gives no rdValid.
- R7: A request whose accSize is not 1, 2, 4 or 8 (4-bit byte count) raises errFlag in the next cycle, leaves storage unchanged and gives no rdValid.
- R8: An accepted load (reqValid=1, wrEn=0, legal) gives rdValid=1 with its data exactly one cycle later. An accepted store gives neither rdValid nor errFlag.
- R9: A cycle with reqValid=0 changes no storage, whatever the other inputs are, and gives rdValid=0 and errFlag=0 in the next cycle.
- R10: Every byte that has never been written reads as 0. This includes the untouched bytes of a word that has received only narrow stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| wrEn | input | 1 | 1 = store, 0 = load |
| byteAddr | input | ADDR_W (16) | Byte address |
| accSize | input | 4 | Access size in bytes (1, 2, 4, 8 legal) |
| wrData | input | 64 | Store data, right-aligned |
| rdData | output | 64 | Load result, right-aligned, zero-filled |
| rdValid | output | 1 | rdData carries a new load result |
| errFlag | output | 1 | Previous request was rejected |

## Verification
A wrong lane shift or mask inside the merge path leaves no trace at the ports until the affected word is loaded again. For that reason every store in the sequence is followed by full-word and narrow loads of the same word, so a corrupted neighbouring byte shows up within two cycles. A faulty legality decode shows up in the very next cycle, either as a missing or spurious errFlag or as a changed word on the following load. Faults in the written-flag or index slicing appear as non-zero reads of fresh words or as broken aliasing of high address bits.

// File: rtl/lane_mem_pkg.sv
package lane_mem_pkg;
  localparam int WORD_BYTES = 8;
  localparam int DATA_W     = WORD_BYTES * 8;
  localparam int OFS_W      = $clog2(WORD_BYTES);
  localparam int SIZE_W     = 4;
  localparam int SHIFT_W    = $clog2(DATA_W);

  // Strobes from control to datapath
  typedef struct packed {
    logic               wrStb;
    logic               rdStb;
    logic               errStb;
    logic [SHIFT_W-1:0] laneShift;
    logic [DATA_W-1:0]  widthMask;
  } memStrobe_t;
endpackage

// File: rtl/lane_mem_ctrl.sv
module lane_mem_ctrl
  import lane_mem_pkg::*;
(
  input  logic              reqValid,
  input  logic              wrEn,
  input  logic [OFS_W-1:0]  byteOfs,
  input  logic [SIZE_W-1:0] accSize,
  output memStrobe_t        strb
);
  logic              sizeLegal;
  logic              alignOk;
  logic [OFS_W-1:0]  alignMask;
  logic [DATA_W-1:0] widthMask;
  logic [OFS_W-1:0]  laneSlot;
  logic              reqOk;

  // Size decode: legal byte counts and their width masks
  always_comb begin
    sizeLegal = 1'b1;
    alignMask = '0;
    widthMask = '0;
    case (accSize)
      4'd1: begin alignMask = 3'd0; widthMask = {{(DATA_W-8){1'b0}},  {8{1'b1}}};  end
      4'd2: begin alignMask = 3'd1; widthMask = {{(DATA_W-16){1'b0}}, {16{1'b1}}}; end
      4'd4: begin alignMask = 3'd3; widthMask = {{(DATA_W-32){1'b0}}, {32{1'b1}}}; end
      4'd8: begin alignMask = 3'd7; widthMask = {DATA_W{1'b1}};                    end
      default: sizeLegal = 1'b0;
    endcase
  end

  assign alignOk = (byteOfs & alignMask) == '0;
  assign reqOk   = sizeLegal && alignOk;

  // Big-endian lane: slot = (8 - size - offset) mod 8 = ~(size + offset - 1)
  assign laneSlot = ~(byteOfs + accSize[OFS_W-1:0] - 3'd1);

  always_comb begin
    strb.wrStb     = reqValid && wrEn && reqOk;
    strb.rdStb     = reqValid && !wrEn && reqOk;
    strb.errStb    = reqValid && !reqOk;
    strb.laneShift = {laneSlot, 3'b000};
    strb.widthMask = widthMask;
  end
endmodule

// File: rtl/lane_mem_dp.sv
module lane_mem_dp
  import lane_mem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  memStrobe_t        strb,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              errFlag
);
  logic [DATA_W-1:0] wordStore [DEPTH];
  logic [DEPTH-1:0]  written;
  logic [DATA_W-1:0] curWord;
  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] laneData;
  logic [DATA_W-1:0] nextWord;
  logic [DATA_W-1:0] loadLane;
  logic              fullWidth;

  // Words never written read as zero
  assign curWord  = written[wordIdx] ? wordStore[wordIdx] : '0;

  assign laneMask  = strb.widthMask << strb.laneShift;
  assign laneData  = (wrData & strb.widthMask) << strb.laneShift;
  assign fullWidth = &strb.widthMask;
  assign nextWord  = fullWidth ? wrData : ((curWord & ~laneMask) | laneData);

  assign loadLane  = (curWord >> strb.laneShift) & strb.widthMask;

  always_ff @(posedge clk) begin
    if (strb.wrStb) wordStore[wordIdx] <= nextWord;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      written <= '0;
      rdValid <= 1'b0;
      errFlag <= 1'b0;
      rdData  <= '0;
    end else begin
      if (strb.wrStb) written[wordIdx] <= 1'b1;
      rdValid <= strb.rdStb;
      errFlag <= strb.errStb;
      if (strb.rdStb) rdData <= loadLane;
    end
  end
endmodule

// File: rtl/lane_mem.sv
module lane_mem
  import lane_mem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic [SIZE_W-1:0] accSize,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              errFlag
);
  localparam int IDX_W = $clog2(DEPTH);

  memStrobe_t       strb;
  logic [IDX_W-1:0] wordIdx;

  assign wordIdx = byteAddr[OFS_W +: IDX_W];

  generate
    if (ADDR_W > OFS_W + IDX_W) begin : g_hiAddr
      logic unusedAddrHi;
      assign unusedAddrHi = ^byteAddr[ADDR_W-1:OFS_W+IDX_W];
    end
  endgenerate

  lane_mem_ctrl u_ctrl (
    .reqValid (reqValid),
    .wrEn     (wrEn),
    .byteOfs  (byteAddr[OFS_W-1:0]),
    .accSize  (accSize),
    .strb     (strb)
  );

  lane_mem_dp #(.DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .wordIdx (wordIdx),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid),
    .errFlag (errFlag)
  );
endmodule

// File: rtl/lane_mem_chk.sv
module lane_mem_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              wrEn,
  input logic [ADDR_W-1:0] byteAddr,
  input logic [3:0]        accSize,
  input logic              rdValid,
  input logic              errFlag
);
  logic sizeGood;
  assign sizeGood = (accSize == 4'd1) || (accSize == 4'd2) ||
                    (accSize == 4'd4) || (accSize == 4'd8);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> !rdValid && !errFlag); // R1
  AST_NO_DUAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdValid && errFlag)); // R6
  AST_HALF_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && accSize == 4'd2 && byteAddr[0] |=> errFlag && !rdValid); // R6
  AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && accSize == 4'd4 && byteAddr[1:0] != 2'd0 |=> errFlag); // R6
  AST_BAD_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !sizeGood |=> errFlag && !rdValid); // R7
  AST_LOAD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && !wrEn && accSize == 4'd8 && byteAddr[2:0] == 3'd0 |=> rdValid); // R8
  AST_STORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid && wrEn && accSize == 4'd1 |=> !rdValid && !errFlag); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rdValid && !errFlag); // R9
endmodule

bind lane_mem lane_mem_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .wrEn     (wrEn),
  .byteAddr (byteAddr),
  .accSize  (accSize),
  .rdValid  (rdValid),
  .errFlag  (errFlag)
);

// File: tb/lane_mem_tb.sv
module lane_mem_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] byteAddr = '0;
  logic [3:0]  accSize = 4'd8;
  logic [63:0] wrData = '0;
  logic [63:0] rdData;
  logic        rdValid;
  logic        errFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  typedef struct {
    logic        expRv;
    logic        expErr;
    logic [63:0] expData;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [7:0] bmem [2048];

  always #10 clk = ~clk;

  lane_mem u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .wrEn(wrEn),
    .byteAddr(byteAddr), .accSize(accSize), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .errFlag(errFlag)
  );

  function automatic int baseOf(logic [15:0] a);
    return ((int'(a) >> 3) & 255) * 8 + (int'(a) & 7);
  endfunction

  function automatic bit legalReq(logic [15:0] a, logic [3:0] s);
    if (!(s == 1 || s == 2 || s == 4 || s == 8)) return 0;
    return (int'(a[2:0]) % int'(s)) == 0;
  endfunction

  // Driver: one request per cycle, expectation pushed from a byte model
  task automatic drive(logic v, logic w, logic [15:0] a, logic [3:0] s,
                       logic [63:0] d, string tag);
    expItem_t it;
    @(negedge clk);
    reqValid = v; wrEn = w; byteAddr = a; accSize = s; wrData = d;
    it.expRv = 0; it.expErr = 0; it.expData = '0; it.tag = tag;
    if (v) begin
      if (!legalReq(a, s)) it.expErr = 1;
      else if (w) begin
        for (int i = 0; i < int'(s); i++)
          bmem[baseOf(a) + i] = d[(int'(s) - 1 - i) * 8 +: 8];
      end else begin
        it.expRv = 1;
        for (int i = 0; i < int'(s); i++)
          it.expData = (it.expData << 8) | 64'(bmem[baseOf(a) + i]);
      end
    end
    expQ.push_back(it);
  endtask

  task automatic ld(logic [15:0] a, logic [3:0] s, string tag);
    drive(1, 0, a, s, 64'hDEAD_BEEF_0BAD_F00D, tag);
  endtask

  task automatic st(logic [15:0] a, logic [3:0] s, logic [63:0] d, string tag);
    drive(1, 1, a, s, d, tag);
  endtask

  task automatic idle(string tag);
    drive(0, 0, 16'h0, 4'd8, 64'h0, tag);
  endtask

  // Monitor: compare outputs one cycle after each request
  always @(posedge clk) begin
    #5;
    if (expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      testsRun++;
      if (rdValid !== it.expRv || errFlag !== it.expErr ||
          (it.expRv && rdData !== it.expData)) begin
        testsFailed++;
        $display("FAIL %s: rv=%0b err=%0b data=%016h, expected rv=%0b err=%0b data=%016h",
                 it.tag, rdValid, errFlag, rdData, it.expRv, it.expErr, it.expData);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    testsRun++;
    if (rdValid !== 1'b0 || errFlag !== 1'b0 || rdData !== 64'h0) begin
      testsFailed++;
      $display("FAIL R1: rv=%0b err=%0b data=%016h, expected 0 0 0", rdValid, errFlag, rdData);
    end
    rst_n = 1'b1;
    idle("R1");
    idle("R9");

    // R10: fresh words read zero
    ld(16'h0040, 4'd8, "R10");
    ld(16'h0123, 4'd1, "R10");

    // R5 / R3: full store then lane loads
    st(16'h0000, 4'd8, 64'h0011_2233_4455_6677, "R5");
    ld(16'h0000, 4'd8, "R5");
    ld(16'h0000, 4'd1, "R3");
    ld(16'h0007, 4'd1, "R3");
    ld(16'h0002, 4'd2, "R3");
    ld(16'h0004, 4'd4, "R3");
    ld(16'h0000, 4'd4, "R3");
    ld(16'h0006, 4'd2, "R3");

    // R4: narrow stores keep other bytes, upper wrData ignored
    st(16'h0003, 4'd1, 64'hFFFF_FFFF_FFFF_FFAB, "R4");
    ld(16'h0000, 4'd8, "R4");
    st(16'h0006, 4'd2, 64'h1234_5678_9ABC_C0DE, "R4");
    ld(16'h0000, 4'd8, "R4");
    st(16'h0004, 4'd4, 64'h5555_5555_CAFE_F00D, "R4");
    ld(16'h0000, 4'd8, "R4");

    // R10: narrow store into a fresh word leaves zeros elsewhere
    st(16'h0085, 4'd1, 64'h0000_0000_0000_005A, "R10");
    ld(16'h0080, 4'd8, "R10");

    // R6: misaligned requests rejected and store has no effect
    st(16'h0001, 4'd2, 64'h0000_0000_0000_EEEE, "R6");
    ld(16'h0000, 4'd8, "R6");
    ld(16'h0002, 4'd4, "R6");
    st(16'h0004, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    ld(16'h0000, 4'd8, "R6");

    // R7: illegal size codes rejected
    st(16'h0000, 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    st(16'h0000, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    ld(16'h0000, 4'd15, "R7");
    ld(16'h0000, 4'd8, "R7");

    // R2: high address bits alias
    st(16'h0808, 4'd8, 64'hA1B2_C3D4_E5F6_0718, "R2");
    ld(16'h0008, 4'd8, "R2");
    ld(16'hF80C, 4'd4, "R2");

    // R9: no request means no write
    drive(0, 1, 16'h0008, 4'd8, 64'h0, "R9");
    ld(16'h0008, 4'd8, "R9");

    // R8: back-to-back store/load sweep across every byte offset
    for (int k = 0; k < 8; k++) begin
      st(16'h0010 + 16'(k), 4'd1, 64'(8'h10 + k), "R8");
      ld(16'h0010 + 16'(k), 4'd1, "R8");
    end
    ld(16'h0010, 4'd8, "R8");
    for (int k = 0; k < 4; k++) ld(16'h0010 + 16'(2 * k), 4'd2, "R3");

    idle("R9");
    idle("R9");
    while (expQ.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule